// File: doc/BRIEF.md
# Handshake Bus Clock-Domain Crossing

This block carries one multi-bit word at a time from a transmit clock domain into a receive clock domain that has no fixed phase or frequency relation to it. The word does not pass through a memory buffer. A four-phase request and acknowledge handshake brings it across instead. On the transmit side, a send strobe in an idle cycle loads the word into a transmit register and raises a registered request. The request reaches the receive clock through a flip-flop chain. When the synchronized request arrives, every bit of the held word is copied on one receive edge into a hold register, and a ready flag rises.

The receive logic reads the word while ready is high and then pulses an acknowledge. A register in the receive domain holds that acknowledge. It passes through a second flip-flop chain into the transmit clock. When the synchronized acknowledge is seen high, the request drops and a done pulse is given. The receive side releases its acknowledge only after it sees the request fall. The transmit side returns to idle only after it sees the acknowledge fall. A send made during this time is dropped and reported. Each domain has its own active-low reset.

Top module: `hs_bus_cdc`

## Requirements
- R1: While txRstN is low, txBusy, txDone and txDropped read 0. While rxRstN is low, rxReady reads 0 and rxData reads all zeros.
- R2: A txSend in a cycle where txBusy is 0 is accepted. txBusy reads 1 after that tx edge, and the word delivered is the txData of the accepting edge, whatever txData does later.
- R3: After an accepted send, rxReady rises within SYNC_STAGES+3 rx cycles, and rxData then equals the sent word.
- R4: While rxReady is high and rxAck is low, rxReady stays high and rxData stays unchanged, for any number of cycles.
- R5: An rxAck sampled high while rxReady is high clears rxReady on that rx edge.
- R6: Each transfer gives exactly one txDone pulse of one tx cycle, after the acknowledge is seen. txBusy stays 1 until the acknowledge has been seen low again, and then returns to 0.
- R7: A txSend while txBusy is 1 does not start a transfer and does not change the word in flight. txDropped reads 1 for the one tx cycle after that edge.
- R8: An rxAck while rxReady is 0 has no effect. No txDone follows, and the next transfer still holds rxReady until its own acknowledge.
- R9: The synchronizer depth is the parameter SYNC_STAGES, which defaults to 2. Values below 2 are raised to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| txClk | input | 1 | Transmit clock |
| txRstN | input | 1 | Transmit-domain reset, active low |
| txData | input | WIDTH | Word to send |
| txSend | input | 1 | Send strobe, sampled on txClk |
| txBusy | output | 1 | Transfer in progress, so sends are refused |
| txDone | output | 1 | One-cycle pulse when the acknowledge arrives |
| txDropped | output | 1 | One-cycle pulse after a refused send |
| rxClk | input | 1 | Receive clock |
| rxRstN | input | 1 | Receive-domain reset, active low |
| rxReady | output | 1 | Held word is valid |
| rxData | output | WIDTH | Held word |
| rxAck | input | 1 | Read acknowledge, sampled on rxClk |

## Verification
The tx-side results are due one tx cycle after the stimulus edge: txBusy after an accepted send and txDropped after a refused one. rxReady clears one rx cycle after an acknowledge. These are sampled at the next falling edge of their own clock. Results that cross the domains have no exact cycle: rxReady after a send, and txDone after an acknowledge. The bench waits for them at falling edges and counts the cycles against a fixed bound of SYNC_STAGES+3 rx cycles for ready and 20 tx cycles for done. It fails the check if the bound runs out, and it samples the data and the pulse widths once the event is seen.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;

  // Strobes from the control to the datapath, one per domain.
  typedef struct packed {
    logic txLoad;     // tx domain: latch the outgoing word
    logic rxCapture;  // rx domain: copy the whole word on this edge
  } hsStrobes_t;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_REQ     = 2'd1,
    TX_RELEASE = 2'd2
  } txState_t;

endpackage

// File: rtl/hs_cdc_sync.sv
module hs_cdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  // Depth below two is not a synchronizer; raise it (R9).
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/hs_cdc_ctrl.sv
module hs_cdc_ctrl
  import hs_cdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       txClk,
  input  logic       txRstN,
  input  logic       txSend,
  output logic       txBusy,
  output logic       txDone,
  output logic       txDropped,
  input  logic       rxClk,
  input  logic       rxRstN,
  input  logic       rxAck,
  output logic       rxReady,
  output hsStrobes_t strobes
);
  txState_t txState;
  logic     reqReg, doneReg, dropReg, ackSync;
  logic     reqSync, readyReg, ackReg;

  // Request into the rx domain, acknowledge back into tx.
  hs_cdc_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(rxClk), .rstN(rxRstN), .d(reqReg), .q(reqSync));
  hs_cdc_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(txClk), .rstN(txRstN), .d(ackReg), .q(ackSync));

  // ---------------- transmit protocol machine ----------------
  always_ff @(posedge txClk or negedge txRstN) begin
    if (!txRstN) begin
      txState <= TX_IDLE;
      reqReg  <= 1'b0;
      doneReg <= 1'b0;
      dropReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      dropReg <= 1'b0;
      case (txState)
        TX_IDLE: if (txSend) begin
          txState <= TX_REQ;
          reqReg  <= 1'b1;
        end
        TX_REQ: begin
          if (txSend) dropReg <= 1'b1;
          if (ackSync) begin
            reqReg  <= 1'b0;
            doneReg <= 1'b1;
            txState <= TX_RELEASE;
          end
        end
        TX_RELEASE: begin
          if (txSend)   dropReg <= 1'b1;
          if (!ackSync) txState <= TX_IDLE;
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  assign txBusy         = (txState != TX_IDLE);
  assign txDone         = doneReg;
  assign txDropped      = dropReg;
  assign strobes.txLoad = (txState == TX_IDLE) && txSend;

  // ---------------- receive protocol machine ----------------
  assign strobes.rxCapture = reqSync && !readyReg && !ackReg;

  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN) begin
      readyReg <= 1'b0;
      ackReg   <= 1'b0;
    end else begin
      if (strobes.rxCapture) begin
        readyReg <= 1'b1;
      end else if (readyReg && rxAck) begin
        readyReg <= 1'b0;
        ackReg   <= 1'b1;
      end
      if (ackReg && !reqSync) ackReg <= 1'b0;
    end
  end

  assign rxReady = readyReg;

  // ---------------- assertions ----------------
  p_done_pulse_r6: assert property (@(posedge txClk) disable iff (!txRstN)
    txDone |=> !txDone);
  p_req_held_r6: assert property (@(posedge txClk) disable iff (!txRstN)
    reqReg && !ackSync |=> reqReg);
  p_busy_drop_r7: assert property (@(posedge txClk) disable iff (!txRstN)
    txSend && txBusy |=> txDropped);
  p_ack_clears_r5: assert property (@(posedge rxClk) disable iff (!rxRstN)
    readyReg && rxAck |=> !readyReg);
  p_ready_needs_req_r3: assert property (@(posedge rxClk) disable iff (!rxRstN)
    $rose(readyReg) |-> reqSync);
endmodule

// File: rtl/hs_cdc_datapath.sv
module hs_cdc_datapath
  import hs_cdc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             txClk,
  input  logic             txRstN,
  input  logic [WIDTH-1:0] txData,
  input  logic             rxClk,
  input  logic             rxRstN,
  input  hsStrobes_t       strobes,
  input  logic             rxReady,
  input  logic             rxAck,
  output logic [WIDTH-1:0] rxData
);
  logic [WIDTH-1:0] txReg, rxHold;

  // Outgoing word, frozen from acceptance until the next send.
  always_ff @(posedge txClk or negedge txRstN) begin
    if (!txRstN)             txReg <= '0;
    else if (strobes.txLoad) txReg <= txData;
  end

  // All bits taken on one rx edge, gated by the synchronized request.
  always_ff @(posedge rxClk or negedge rxRstN) begin
    if (!rxRstN)                rxHold <= '0;
    else if (strobes.rxCapture) rxHold <= txReg;
  end

  assign rxData = rxHold;

  p_hold_stable_r4: assert property (@(posedge rxClk) disable iff (!rxRstN)
    rxReady && !rxAck |=> $stable(rxHold));
endmodule

// File: rtl/hs_bus_cdc.sv
module hs_bus_cdc
  import hs_cdc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             txClk,
  input  logic             txRstN,
  input  logic [WIDTH-1:0] txData,
  input  logic             txSend,
  output logic             txBusy,
  output logic             txDone,
  output logic             txDropped,
  input  logic             rxClk,
  input  logic             rxRstN,
  output logic             rxReady,
  output logic [WIDTH-1:0] rxData,
  input  logic             rxAck
);
  hsStrobes_t strobes;

  hs_cdc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .txClk(txClk), .txRstN(txRstN), .txSend(txSend),
    .txBusy(txBusy), .txDone(txDone), .txDropped(txDropped),
    .rxClk(rxClk), .rxRstN(rxRstN), .rxAck(rxAck),
    .rxReady(rxReady), .strobes(strobes));

  hs_cdc_datapath #(.WIDTH(WIDTH)) u_data (
    .txClk(txClk), .txRstN(txRstN), .txData(txData),
    .rxClk(rxClk), .rxRstN(rxRstN), .strobes(strobes),
    .rxReady(rxReady), .rxAck(rxAck), .rxData(rxData));
endmodule

// File: tb/hs_bus_cdc_tb.sv
`timescale 1ns/1ps
module hs_bus_cdc_tb;
  localparam int W     = 16;
  localparam int SYNC  = 2;
  localparam int RDYMAX = SYNC + 3;
  localparam int NVEC  = 6;
  // {data[19:4], ack hold cycles[3:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    20'hA5A5_1, 20'h0000_3, 20'hFFFF_0, 20'h1234_7, 20'h8001_2, 20'h7FFE_5};

  logic txClk = 0, rxClk = 0, txRstN = 0, rxRstN = 0;
  logic [W-1:0] txData = '0;
  logic txSend = 0, rxAck = 0;
  logic txBusy, txDone, txDropped, rxReady;
  logic [W-1:0] rxData;
  int runs = 0, fails = 0;
  bit finished = 0;

  always #10 txClk = ~txClk;   // 50 MHz
  always #17 rxClk = ~rxClk;   // unrelated receive clock

  hs_bus_cdc #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut (
    .txClk(txClk), .txRstN(txRstN), .txData(txData), .txSend(txSend),
    .txBusy(txBusy), .txDone(txDone), .txDropped(txDropped),
    .rxClk(rxClk), .rxRstN(rxRstN), .rxReady(rxReady), .rxData(rxData),
    .rxAck(rxAck));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [W-1:0] d);
    @(negedge txClk); txData = d; txSend = 1;
    @(negedge txClk); txSend = 0; txData = ~d;
    check(txBusy == 1'b1, "R2 busy after accept", txBusy, 1);
  endtask

  task automatic waitReady(input logic [W-1:0] d);
    int n = 0;
    while (!rxReady && n < RDYMAX) begin @(negedge rxClk); n++; end
    check(rxReady == 1'b1, "R3 ready within bound", n, RDYMAX);
    check(rxData == d, "R3 R2 delivered word", rxData, d);
  endtask

  task automatic holdAndAck(input int hold, input logic [W-1:0] d);
    for (int i = 0; i < hold; i++) @(negedge rxClk);
    check(rxReady == 1'b1 && rxData == d, "R4 held until ack", {rxReady, rxData}, {1'b1, d});
    rxAck = 1; @(negedge rxClk); rxAck = 0;
    check(rxReady == 1'b0, "R5 ack clears ready", rxReady, 0);
  endtask

  task automatic waitDone();
    int n = 0, hi = 0;
    while (txBusy && n < 20) begin
      @(negedge txClk); n++;
      if (txDone) hi++;
    end
    check(txBusy == 1'b0, "R6 busy returns low", txBusy, 0);
    check(hi == 1, "R6 single done pulse", hi, 1);
  endtask

  initial begin
    repeat (200000) @(posedge txClk);
    if (!finished) begin
      fails++; runs++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge txClk);
    check({txBusy, txDone, txDropped} == 3'b000, "R1 tx reset", {txBusy, txDone, txDropped}, 0);
    check(rxReady == 0 && rxData == '0, "R1 rx reset", {rxReady, rxData}, 0);
    txRstN = 1; rxRstN = 1;
    repeat (3) @(negedge txClk);

    // Vector table (R9 default depth of 2 sets the ready bound)
    for (int v = 0; v < NVEC; v++) begin
      logic [W-1:0] d = VEC[v][19:4];
      sendWord(d);
      waitReady(d);
      holdAndAck(int'(VEC[v][3:0]), d);
      waitDone();
      repeat (3) @(negedge txClk);
    end

    // R7 send while busy
    sendWord(16'h1111);
    @(negedge txClk); txData = 16'h2222; txSend = 1;
    @(negedge txClk); txSend = 0;
    check(txDropped == 1'b1, "R7 dropped pulse", txDropped, 1);
    @(negedge txClk);
    check(txDropped == 1'b0, "R7 dropped one cycle", txDropped, 0);
    waitReady(16'h1111);
    holdAndAck(1, 16'h1111);
    waitDone();
    repeat (10) @(negedge rxClk);
    check(rxReady == 1'b0 && rxData == 16'h1111, "R7 no second transfer", {rxReady, rxData}, {1'b0, 16'h1111});

    // R8 stray acknowledge while not ready
    @(negedge rxClk); rxAck = 1; @(negedge rxClk); rxAck = 0;
    begin
      int hi = 0;
      for (int i = 0; i < 12; i++) begin @(negedge txClk); if (txDone || txBusy) hi++; end
      check(hi == 0, "R8 stray ack no done", hi, 0);
    end
    sendWord(16'hC3C3);
    waitReady(16'hC3C3);
    holdAndAck(6, 16'hC3C3);
    waitDone();

    // R1 rx-only reset while idle
    repeat (4) @(negedge rxClk);
    rxRstN = 0; @(negedge rxClk);
    check(rxReady == 0 && rxData == '0, "R1 rx reset alone", {rxReady, rxData}, 0);
    rxRstN = 1;
    // R1 tx-only reset mid-transfer
    sendWord(16'h5A5A);
    txRstN = 0; @(negedge txClk);
    check({txBusy, txDone, txDropped} == 3'b000, "R1 tx reset alone", {txBusy, txDone, txDropped}, 0);
    txRstN = 1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule